// File: doc/BRIEF.md
# Regulator Fault Latch Supervisor

This block gathers the protection events of a single-phase buck regulator and decides what the gate drivers and the power-good indicator may do. It takes digital comparator bits from the analog front end:

- output below the soft-start reference by the undervoltage margin
- output above the reference by the overvoltage margin
- output above the severe-overvoltage high threshold
- output below the severe-overvoltage low threshold

It also takes an overcurrent fault flag from an external detector, the regulator enable level and an active-low power-on reset. All inputs are synchronous to `clk`.

Undervoltage and overvoltage must each persist for a qualification window before they latch. Overcurrent latches at once. Any of these ordinary faults turns off both gates and drops power-good until enable is taken low or power-on reset is applied. Severe overvoltage is handled on its own path. It latches on the first sampled high-threshold crossing and holds the high-side gate and power-good off. It also drives the low-side gate on and off with hysteresis between the two severe thresholds. Only power-on reset ends this state, and it can start even while an ordinary fault is already latched.

Top module: `fault_latch_supervisor`

## Requirements
- R1: While `porN` is low every latch and timer is cleared. After its release, with `enableIn` high and no fault input asserted, `hsGateEn`, `lsGateEn` and `powerGood` are 1 and `lsGateForce` is 0.
- R2: An undervoltage fault latches on the clock edge at which `uvCmp` has been sampled high with `enableIn` high for `UV_QUAL_CYCLES` consecutive edges. Fewer consecutive edges latch nothing.
- R3: An overvoltage fault latches on the clock edge at which `ovCmp` has been sampled high with `enableIn` high for `OV_QUAL_CYCLES` consecutive edges. Fewer consecutive edges latch nothing.
- R4: One sampled low on `uvCmp` or `ovCmp` restarts that condition's count from zero.
- R5: `ocFault` sampled high with `enableIn` high latches an overcurrent fault on that edge.
- R6: While any ordinary fault (undervoltage, overvoltage, overcurrent) is latched, `hsGateEn`, `lsGateEn` and `powerGood` are 0.
- R7: While `enableIn` is low, `hsGateEn`, `lsGateEn` and `powerGood` are 0. Ordinary latches and qualification counts are cleared and held clear, and fault inputs seen in that time latch nothing. Raising `enableIn` again with no faults restores all three outputs to 1.
- R8: `sevAboveHigh` sampled high latches the severe state on that edge. From then on `hsGateEn`, `lsGateEn` and `powerGood` are 0.
- R9: `lsGateForce` is 1 after an edge with `sevAboveHigh` high. It is 0 after an edge with `sevBelowLow` high and `sevAboveHigh` low. Otherwise it holds its value. It is 0 whenever the severe state is not latched.
- R10: The severe state is not cleared by `enableIn`. `lsGateForce` keeps following R9 and `powerGood` stays 0 until `porN` goes low.
- R11: The severe state latches and `lsGateForce` toggles per R9 even while an ordinary fault is latched, overriding the ordinary gate-off for the low-side force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Active-low power-on reset, asynchronous assert |
| enableIn | input | 1 | Regulator enable level; low clears ordinary faults |
| uvCmp | input | 1 | Output below reference by the undervoltage margin |
| ovCmp | input | 1 | Output above reference by the overvoltage margin |
| ocFault | input | 1 | Overcurrent fault flag from the external detector |
| sevAboveHigh | input | 1 | Output above the severe-overvoltage high threshold |
| sevBelowLow | input | 1 | Output below the severe-overvoltage low threshold |
| hsGateEn | output | 1 | High-side gate may switch |
| lsGateEn | output | 1 | Low-side gate may switch under normal control |
| lsGateForce | output | 1 | Low-side gate forced on by severe-overvoltage control |
| powerGood | output | 1 | Power-good indication |

## Verification
The bound checker watches these rules on every cycle:
- the enable gating of all three outputs
- the one-edge reaction to overcurrent
- the set and reset edges of the low-side hysteresis
- the exclusion between a forced low side and any other output being on
- the undervoltage window, measured with its own run counter

Some behaviour only the bench scenarios can show:
- the exact threshold of each qualification window, swept across every hold length around it
- the restart after a dropout
- that enable never clears the severe state
- that a latched ordinary fault does not block the severe path, and that power-on reset is the only way out of it

// File: rtl/fls_pkg.sv
package fls_pkg;
  localparam int NUM_QUAL = 2;
  localparam int QUAL_UV = 0;
  localparam int QUAL_OV = 1;

  typedef struct packed {
    logic clearTimers;
  } ctlStrobe_t;

  typedef struct packed {
    logic [NUM_QUAL-1:0] qualified;
  } qualStrobe_t;
endpackage

// File: rtl/fls_qual_timer.sv
module fls_qual_timer #(
  parameter int QUAL_CYCLES = 50000
) (
  input  logic clk,
  input  logic porN,
  input  logic clearIn,
  input  logic condIn,
  output logic qualifiedOut
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LAST_COUNT = CW'(QUAL_CYCLES - 1);
  localparam logic [CW-1:0] MAX_COUNT  = CW'(QUAL_CYCLES);

  logic [CW-1:0] runCount;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      runCount <= '0;
    end else if (clearIn || !condIn) begin
      runCount <= '0;
    end else if (runCount != MAX_COUNT) begin
      runCount <= runCount + 1'b1;
    end
  end

  always_comb begin
    qualifiedOut = condIn && !clearIn && (runCount >= LAST_COUNT);
  end
endmodule

// File: rtl/fls_datapath.sv
module fls_datapath
  import fls_pkg::*;
#(
  parameter int UV_QUAL_CYCLES = 50000,
  parameter int OV_QUAL_CYCLES = 50000
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        uvCmp,
  input  logic        ovCmp,
  input  ctlStrobe_t  ctlIn,
  output qualStrobe_t qualOut
);
  logic [NUM_QUAL-1:0] condVec;

  always_comb begin
    condVec = '0;
    condVec[QUAL_UV] = uvCmp;
    condVec[QUAL_OV] = ovCmp;
  end

  for (genvar g = 0; g < NUM_QUAL; g++) begin : gen_qual
    localparam int Q = (g == QUAL_UV) ? UV_QUAL_CYCLES : OV_QUAL_CYCLES;
    fls_qual_timer #(.QUAL_CYCLES(Q)) u_timer (
      .clk          (clk),
      .porN         (porN),
      .clearIn      (ctlIn.clearTimers),
      .condIn       (condVec[g]),
      .qualifiedOut (qualOut.qualified[g])
    );
  end
endmodule

// File: rtl/fls_control.sv
module fls_control
  import fls_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        enableIn,
  input  logic        ocFault,
  input  logic        sevAboveHigh,
  input  logic        sevBelowLow,
  input  qualStrobe_t qualIn,
  output ctlStrobe_t  ctlOut,
  output logic        hsGateEn,
  output logic        lsGateEn,
  output logic        lsGateForce,
  output logic        powerGood
);
  logic uvLatched;
  logic ovLatched;
  logic ocLatched;
  logic sevLatched;
  logic forceOn;
  logic ordFault;
  logic runAllowed;

  always_comb begin
    ctlOut.clearTimers = !enableIn;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      uvLatched <= 1'b0;
      ovLatched <= 1'b0;
      ocLatched <= 1'b0;
    end else if (!enableIn) begin
      uvLatched <= 1'b0;
      ovLatched <= 1'b0;
      ocLatched <= 1'b0;
    end else begin
      if (qualIn.qualified[QUAL_UV]) uvLatched <= 1'b1;
      if (qualIn.qualified[QUAL_OV]) ovLatched <= 1'b1;
      if (ocFault)                   ocLatched <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      sevLatched <= 1'b0;
      forceOn    <= 1'b0;
    end else begin
      if (sevAboveHigh) begin
        sevLatched <= 1'b1;
        forceOn    <= 1'b1;
      end else if (sevBelowLow) begin
        forceOn    <= 1'b0;
      end
    end
  end

  always_comb begin
    ordFault    = uvLatched || ovLatched || ocLatched;
    runAllowed  = enableIn && !ordFault && !sevLatched;
    hsGateEn    = runAllowed;
    lsGateEn    = runAllowed;
    powerGood   = runAllowed;
    lsGateForce = sevLatched && forceOn;
  end
endmodule

// File: rtl/fault_latch_supervisor.sv
module fault_latch_supervisor
  import fls_pkg::*;
#(
  parameter int UV_QUAL_CYCLES = 50000,
  parameter int OV_QUAL_CYCLES = 50000
) (
  input  logic clk,
  input  logic porN,
  input  logic enableIn,
  input  logic uvCmp,
  input  logic ovCmp,
  input  logic ocFault,
  input  logic sevAboveHigh,
  input  logic sevBelowLow,
  output logic hsGateEn,
  output logic lsGateEn,
  output logic lsGateForce,
  output logic powerGood
);
  ctlStrobe_t  ctlBus;
  qualStrobe_t qualBus;

  fls_datapath #(
    .UV_QUAL_CYCLES (UV_QUAL_CYCLES),
    .OV_QUAL_CYCLES (OV_QUAL_CYCLES)
  ) u_datapath (
    .clk     (clk),
    .porN    (porN),
    .uvCmp   (uvCmp),
    .ovCmp   (ovCmp),
    .ctlIn   (ctlBus),
    .qualOut (qualBus)
  );

  fls_control u_control (
    .clk          (clk),
    .porN         (porN),
    .enableIn     (enableIn),
    .ocFault      (ocFault),
    .sevAboveHigh (sevAboveHigh),
    .sevBelowLow  (sevBelowLow),
    .qualIn       (qualBus),
    .ctlOut       (ctlBus),
    .hsGateEn     (hsGateEn),
    .lsGateEn     (lsGateEn),
    .lsGateForce  (lsGateForce),
    .powerGood    (powerGood)
  );
endmodule

// File: rtl/fls_checker.sv
module fls_checker #(
  parameter int UV_QUAL_CYCLES = 50000
) (
  input logic clk,
  input logic porN,
  input logic enableIn,
  input logic uvCmp,
  input logic ocFault,
  input logic sevAboveHigh,
  input logic sevBelowLow,
  input logic hsGateEn,
  input logic lsGateEn,
  input logic lsGateForce,
  input logic powerGood
);
  int uvRun;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      uvRun <= 0;
    end else if (!(uvCmp && enableIn)) begin
      uvRun <= 0;
    end else if (uvRun < UV_QUAL_CYCLES) begin
      uvRun <= uvRun + 1;
    end
  end

  assert_uv_window_R2: assert property (@(posedge clk) disable iff (!porN)
    (uvCmp && enableIn && uvRun >= UV_QUAL_CYCLES - 1) |=> !powerGood);

  assert_oc_latch_R5: assert property (@(posedge clk) disable iff (!porN)
    (ocFault && enableIn) |=> (!powerGood && !hsGateEn && !lsGateEn));

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!porN)
    !enableIn |-> (!hsGateEn && !lsGateEn && !powerGood));

  assert_force_set_R9: assert property (@(posedge clk) disable iff (!porN)
    sevAboveHigh |=> lsGateForce);

  assert_force_clear_R9: assert property (@(posedge clk) disable iff (!porN)
    (sevBelowLow && !sevAboveHigh) |=> !lsGateForce);

  assert_force_exclusive_R8: assert property (@(posedge clk) disable iff (!porN)
    lsGateForce |-> (!hsGateEn && !lsGateEn && !powerGood));

  assert_severe_sticky_R10: assert property (@(posedge clk) disable iff (!porN)
    sevAboveHigh |=> (!powerGood && !hsGateEn));
endmodule

bind fault_latch_supervisor fls_checker #(.UV_QUAL_CYCLES(UV_QUAL_CYCLES)) u_fls_checker (
  .clk          (clk),
  .porN         (porN),
  .enableIn     (enableIn),
  .uvCmp        (uvCmp),
  .ocFault      (ocFault),
  .sevAboveHigh (sevAboveHigh),
  .sevBelowLow  (sevBelowLow),
  .hsGateEn     (hsGateEn),
  .lsGateEn     (lsGateEn),
  .lsGateForce  (lsGateForce),
  .powerGood    (powerGood)
);

// File: tb/fault_latch_supervisor_bench.sv
`timescale 1ns/1ps
module fault_latch_supervisor_bench;
  localparam int UVQ = 4;
  localparam int OVQ = 6;

  logic clk = 1'b0;
  logic porN, enableIn, uvCmp, ovCmp, ocFault, sevAboveHigh, sevBelowLow;
  logic hsGateEn, lsGateEn, lsGateForce, powerGood;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fault_latch_supervisor #(.UV_QUAL_CYCLES(UVQ), .OV_QUAL_CYCLES(OVQ)) u_fault_latch_supervisor (
    .clk(clk), .porN(porN), .enableIn(enableIn), .uvCmp(uvCmp), .ovCmp(ovCmp),
    .ocFault(ocFault), .sevAboveHigh(sevAboveHigh), .sevBelowLow(sevBelowLow),
    .hsGateEn(hsGateEn), .lsGateEn(lsGateEn), .lsGateForce(lsGateForce),
    .powerGood(powerGood)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Expected outputs: run = gates and power-good on, frc = low-side force
  task automatic chkOut(input string req, input logic run, input logic frc);
    chk(req, "hsGateEn", hsGateEn, run);
    chk(req, "lsGateEn", lsGateEn, run);
    chk(req, "powerGood", powerGood, run);
    chk(req, "lsGateForce", lsGateForce, frc);
  endtask

  task automatic clearOrdinary();
    enableIn = 1'b0; tick(1);
    enableIn = 1'b1; tick(1);
  endtask

  task automatic applyPor();
    porN = 1'b0; tick(2);
    porN = 1'b1; tick(1);
  endtask

  initial begin
    porN = 1'b0; enableIn = 1'b1; uvCmp = 1'b0; ovCmp = 1'b0;
    ocFault = 1'b0; sevAboveHigh = 1'b0; sevBelowLow = 1'b0;
    tick(3);
    porN = 1'b1;
    tick(1);
    chkOut("R1", 1'b1, 1'b0);

    // R2: sweep undervoltage hold lengths around the window
    for (int len = 1; len <= UVQ + 2; len++) begin
      clearOrdinary();
      uvCmp = 1'b1; tick(len);
      uvCmp = 1'b0; tick(1);
      chk("R2", $sformatf("powerGood len=%0d", len), powerGood, (len < UVQ));
      if (len >= UVQ) chkOut("R6", 1'b0, 1'b0);
    end

    // R3: sweep overvoltage hold lengths around the window
    for (int len = 1; len <= OVQ + 2; len++) begin
      clearOrdinary();
      ovCmp = 1'b1; tick(len);
      ovCmp = 1'b0; tick(1);
      chk("R3", $sformatf("powerGood len=%0d", len), powerGood, (len < OVQ));
    end

    // R4: a single dropout restarts the count, for every split point
    for (int a = 1; a < UVQ; a++) begin
      clearOrdinary();
      uvCmp = 1'b1; tick(a);
      uvCmp = 1'b0; tick(1);
      uvCmp = 1'b1; tick(UVQ - 1);
      uvCmp = 1'b0; tick(1);
      chk("R4", $sformatf("uv restart a=%0d", a), powerGood, 1'b1);
    end
    clearOrdinary();
    ovCmp = 1'b1; tick(OVQ - 1);
    ovCmp = 1'b0; tick(1);
    ovCmp = 1'b1; tick(OVQ - 1);
    chk("R4", "ov restart", powerGood, 1'b1);
    tick(1);
    chk("R4", "ov full window after restart", powerGood, 1'b0);
    ovCmp = 1'b0;

    // R5, R6, R7: overcurrent latch and clear by enable
    clearOrdinary();
    ocFault = 1'b1; tick(1);
    ocFault = 1'b0; tick(2);
    chkOut("R5", 1'b0, 1'b0);
    enableIn = 1'b0; tick(1);
    chkOut("R7", 1'b0, 1'b0);
    enableIn = 1'b1; tick(1);
    chkOut("R7", 1'b1, 1'b0);

    // R7: fault inputs while enable is low latch nothing
    enableIn = 1'b0;
    ocFault = 1'b1; uvCmp = 1'b1; ovCmp = 1'b1;
    tick(OVQ + 2);
    ocFault = 1'b0; uvCmp = 1'b0; ovCmp = 1'b0;
    enableIn = 1'b1; tick(1);
    chkOut("R7", 1'b1, 1'b0);
    // counts were held clear: UVQ-1 more cycles must not latch
    uvCmp = 1'b1; tick(UVQ - 1);
    uvCmp = 1'b0; tick(1);
    chk("R7", "uv count cleared by enable", powerGood, 1'b1);

    // R8, R9: severe latch and hysteresis sequence
    sevAboveHigh = 1'b1; tick(1);
    chkOut("R8", 1'b0, 1'b1);
    sevAboveHigh = 1'b0; tick(1);
    chkOut("R9", 1'b0, 1'b1);
    sevBelowLow = 1'b1; tick(1);
    chkOut("R9", 1'b0, 1'b0);
    sevBelowLow = 1'b0; tick(2);
    chkOut("R9", 1'b0, 1'b0);
    sevAboveHigh = 1'b1; sevBelowLow = 1'b1; tick(1);
    chk("R9", "high wins over low", lsGateForce, 1'b1);
    sevAboveHigh = 1'b0; sevBelowLow = 1'b0;

    // R10: enable does not clear severe; force still follows
    enableIn = 1'b0; tick(2);
    sevBelowLow = 1'b1; tick(1);
    chk("R10", "force low with enable low", lsGateForce, 1'b0);
    sevBelowLow = 1'b0; sevAboveHigh = 1'b1; tick(1);
    chk("R10", "force high with enable low", lsGateForce, 1'b1);
    sevAboveHigh = 1'b0;
    enableIn = 1'b1; tick(2);
    chkOut("R10", 1'b0, 1'b1);

    // R1: power-on reset clears severe state
    applyPor();
    chkOut("R1", 1'b1, 1'b0);

    // R11: severe after an ordinary fault is latched
    ocFault = 1'b1; tick(1);
    ocFault = 1'b0; tick(1);
    chkOut("R11", 1'b0, 1'b0);
    sevAboveHigh = 1'b1; tick(1);
    sevAboveHigh = 1'b0;
    chkOut("R11", 1'b0, 1'b1);
    sevBelowLow = 1'b1; tick(1);
    sevBelowLow = 1'b0;
    chkOut("R11", 1'b0, 1'b0);
    clearOrdinary();
    chkOut("R11", 1'b0, 1'b0);
    applyPor();
    chkOut("R1", 1'b1, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule